// File: doc/BRIEF.md
# Pin Change Interrupt Monitor

This block watches a group of digital input pins and reports any change of level on them. Each pin is first brought into the local clock domain by a synchronizer chain. Its synchronized level is then compared with the level it had one cycle earlier. When a pin whose change-detect enable is set moves from 0 to 1 or from 1 to 0, one shared flag is set. The flag holds until software clears it.

The interrupt request to a priority controller is the flag gated by a global enable. Software programs three configuration words through a simple write port: the per-pin change-detect enables, the per-pin pull-up enables, and the control word that holds the global enable. The pull-up enables are plain register outputs for the pad ring.

Top module: `pin_change_monitor`

## Requirements
- R1: A rising or a falling level change on any pin whose change-detect enable is 1 sets `chg_flag`. This holds for the lowest pin and for the highest pin.
- R2: A level change on a pin whose change-detect enable is 0 leaves `chg_flag` unchanged.
- R3: A write with `wr_sel` = 1 loads `wr_data` into `pullup_en`. A write with `wr_sel` = 0 loads `wr_data` into `chg_en`. A write to either of these words leaves the other word unchanged.
- R4: `irq` is 1 exactly when `chg_flag` is 1 and the global enable is 1. The global enable is bit 0 of a write with `wr_sel` = 2, and it appears on `glb_en`. Changing the global enable does not alter `chg_en`.
- R5: Once set, `chg_flag` stays at 1 until a cycle with `flag_clr` = 1 and no new change.
- R6: A cycle with `flag_clr` = 1 and no enabled change clears `chg_flag` at the next clock edge.
- R7: If an enabled change and `flag_clr` coincide in the same cycle, `chg_flag` ends up 1.
- R8: Setting a pin's change-detect enable after that pin has toggled while disabled does not set `chg_flag`. The previous-level register follows the pin at all times.
- R9: A level change on a pin, applied before a clock edge, makes `chg_flag` rise on the third rising edge. It does not rise on the first or second edge. This follows from a two-stage synchronizer and a one-cycle comparison.
- R10: After reset, `chg_flag`, `irq`, `chg_en`, `pullup_en` and `glb_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 2 | Target word: 0 change enables, 1 pull-up enables, 2 control |
| wr_data | input | NUM_PINS | Write data; bit 0 is the global enable for the control word |
| flag_clr | input | 1 | Software clear of the change flag |
| chg_en | output | NUM_PINS | Per-pin change-detect enables |
| pullup_en | output | NUM_PINS | Per-pin pull-up enables |
| glb_en | output | 1 | Global change-interrupt enable |
| chg_flag | output | 1 | Sticky shared change flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: 24 pins and two synchronizer stages. With 24 pins, both the edge pin 0 and the edge pin 23 can be driven. With two stages, the flag rises on exactly the third edge, so an R9 check is a precise cycle count. It also lets the bench place the software clear on the exact cycle in which a detected change is pending, which reaches the set-over-clear corner.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  typedef enum logic [1:0] {
    SEL_CHG  = 2'd0,
    SEL_PULL = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/pcm_sync.sv
module pcm_sync #(
  parameter int W      = 24,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
    if (gi == 0) begin : g_first
      always_comb stg_d[gi] = d;
    end else begin : g_next
      always_comb stg_d[gi] = stg_q[gi-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[gi] <= '0;
      else        stg_q[gi] <= stg_d[gi];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/pcm_detect.sv
module pcm_detect #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] en,
  output logic [W-1:0] prev,
  output logic         hit
);
  logic [W-1:0] prev_q;
  logic [W-1:0] prev_d;
  logic [W-1:0] diff;

  // previous level always follows the pin, enabled or not
  always_comb prev_d = cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  always_comb begin
    diff = (cur ^ prev_q) & en;
    hit  = |diff;
  end

  assign prev = prev_q;
endmodule

// File: rtl/pcm_cfg.sv
module pcm_cfg
  import pcm_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] chg_en,
  output logic [W-1:0] pull_en,
  output logic         glb_en
);
  logic [W-1:0] chg_q, chg_d;
  logic [W-1:0] pull_q, pull_d;
  logic         glb_q, glb_d;
  logic         chg_ce, pull_ce, glb_ce;

  always_comb begin
    chg_ce  = 1'b0;
    pull_ce = 1'b0;
    glb_ce  = 1'b0;
    if (wr_en) begin
      case (cfg_sel_e'(wr_sel))
        SEL_CHG:  chg_ce  = 1'b1;
        SEL_PULL: pull_ce = 1'b1;
        SEL_CTRL: glb_ce  = 1'b1;
        default:  ;
      endcase
    end
    chg_d  = wr_data;
    pull_d = wr_data;
    glb_d  = wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chg_q  <= '0;
      pull_q <= '0;
      glb_q  <= 1'b0;
    end else begin
      if (chg_ce)  chg_q  <= chg_d;
      if (pull_ce) pull_q <= pull_d;
      if (glb_ce)  glb_q  <= glb_d;
    end
  end

  assign chg_en  = chg_q;
  assign pull_en = pull_q;
  assign glb_en  = glb_q;
endmodule

// File: rtl/pcm_flag.sv
module pcm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clr,
  output logic flag
);
  logic flag_q, flag_d;

  // a set has priority over a clear in the same cycle
  always_comb begin
    if (hit)      flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
    else          flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/pin_change_monitor.sv
module pin_change_monitor #(
  parameter int NUM_PINS    = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [NUM_PINS-1:0] wr_data,
  input  logic                flag_clr,
  output logic [NUM_PINS-1:0] chg_en,
  output logic [NUM_PINS-1:0] pullup_en,
  output logic                glb_en,
  output logic                chg_flag,
  output logic                irq
);
  logic [NUM_PINS-1:0] pin_sync;
  logic [NUM_PINS-1:0] pin_prev;
  logic                chg_hit;

  pcm_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  pcm_cfg #(.W(NUM_PINS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .chg_en(chg_en), .pull_en(pullup_en), .glb_en(glb_en)
  );

  pcm_detect #(.W(NUM_PINS)) u_det (
    .clk(clk), .rst_n(rst_n), .cur(pin_sync), .en(chg_en),
    .prev(pin_prev), .hit(chg_hit)
  );

  pcm_flag u_flag (
    .clk(clk), .rst_n(rst_n), .hit(chg_hit), .clr(flag_clr), .flag(chg_flag)
  );

  assign irq = chg_flag & glb_en;
endmodule

// File: rtl/pcm_checker.sv
module pcm_checker #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] sync_lvl,
  input logic [W-1:0] prev_lvl,
  input logic [W-1:0] en,
  input logic         hit,
  input logic         clr,
  input logic         flag,
  input logic         glb,
  input logic         irq
);
  a_r5_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);

  a_r7_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);

  a_r6_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !flag);

  a_r4_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !glb |-> !irq);

  a_r2_rise_needs_enabled_change: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> ($past(|((sync_lvl ^ prev_lvl) & en))));

  a_r8_prev_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (prev_lvl == $past(sync_lvl)));
endmodule

bind pin_change_monitor pcm_checker #(.W(NUM_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_lvl(pin_sync), .prev_lvl(pin_prev),
  .en(chg_en), .hit(chg_hit), .clr(flag_clr), .flag(chg_flag),
  .glb(glb_en), .irq(irq)
);

// File: tb/pin_change_monitor_test.sv
`timescale 1ns/1ps
module pin_change_monitor_test;
  localparam int N = 24;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] pins;
  logic         wr_en;
  logic [1:0]   wr_sel;
  logic [N-1:0] wr_data;
  logic         flag_clr;
  logic [N-1:0] chg_en;
  logic [N-1:0] pullup_en;
  logic         glb_en;
  logic         chg_flag;
  logic         irq;

  int n_chk;
  int n_bad;
  bit done;

  pin_change_monitor #(.NUM_PINS(N), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .pin_in(pins), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .flag_clr(flag_clr), .chg_en(chg_en),
    .pullup_en(pullup_en), .glb_en(glb_en), .chg_flag(chg_flag), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [1:0] sel, input logic [N-1:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic flip(input int idx);
    @(negedge clk); pins[idx] = ~pins[idx];
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R10 flag", chg_flag, 0);
    check("R10 irq", irq, 0);
    check("R10 chg_en", chg_en, 0);
    check("R10 pullup_en", pullup_en, 0);
    check("R10 glb_en", glb_en, 0);
  endtask

  task automatic t_edges_latency();
    write_cfg(2'd0, '1);
    settle(); clear_flag();
    flip(0);                       // rising on pin 0
    @(negedge clk); check("R9 after edge 1", chg_flag, 0);
    @(negedge clk); check("R9 after edge 2", chg_flag, 0);
    @(negedge clk); check("R9 after edge 3 / R1 rising", chg_flag, 1);
    clear_flag();
    check("R6 clear", chg_flag, 0);
    flip(0);                       // falling on pin 0
    settle(); check("R1 falling pin 0", chg_flag, 1);
    clear_flag();
    flip(N-1);
    settle(); check("R1 rising top pin", chg_flag, 1);
    clear_flag();
    flip(N-1);
    settle(); check("R1 falling top pin", chg_flag, 1);
    clear_flag();
  endtask

  task automatic t_sticky();
    flip(11);
    settle();
    repeat (12) @(negedge clk);
    check("R5 flag held", chg_flag, 1);
    clear_flag();
    check("R6 clear after hold", chg_flag, 0);
    flip(11); settle(); clear_flag();
  endtask

  task automatic t_set_wins();
    pins[4] = ~pins[4];            // applied at a negedge
    @(negedge clk);                // stage 1 captured
    @(negedge clk); flag_clr = 1'b1; // change pending in this cycle
    @(negedge clk); flag_clr = 1'b0;
    check("R7 set wins over clear", chg_flag, 1);
    clear_flag();
    check("R7 later clear", chg_flag, 0);
  endtask

  task automatic t_disabled();
    write_cfg(2'd0, 24'h000020);   // only pin 5
    flip(3); flip(9);
    settle(); check("R2 disabled pins ignored", chg_flag, 0);
    flip(5);
    settle(); check("R2 enabled pin still works", chg_flag, 1);
    clear_flag();
  endtask

  task automatic t_enable_no_false();
    write_cfg(2'd0, '0);
    flip(7); flip(7); flip(7);     // ends inverted
    settle();
    write_cfg(2'd0, 24'h000080);
    settle();
    check("R8 no false event on enable", chg_flag, 0);
    flip(7);
    settle(); check("R8 real change after enable", chg_flag, 1);
    clear_flag();
  endtask

  task automatic t_pullup();
    write_cfg(2'd0, 24'h3C00F1);
    write_cfg(2'd1, 24'hA5A5A5);
    check("R3 pull-up loaded", pullup_en, 32'hA5A5A5);
    check("R3 change enables kept", chg_en, 32'h3C00F1);
    write_cfg(2'd0, 24'h00FF00);
    check("R3 pull-ups kept", pullup_en, 32'hA5A5A5);
    check("R3 change enables loaded", chg_en, 32'h00FF00);
  endtask

  task automatic t_irq_gate();
    write_cfg(2'd0, 24'h000100);
    flip(8); settle();
    check("R4 flag set, global off", chg_flag, 1);
    check("R4 irq off when global off", irq, 0);
    write_cfg(2'd2, 24'h000001);
    check("R4 glb_en on", glb_en, 1);
    check("R4 irq on", irq, 1);
    write_cfg(2'd2, 24'h000000);
    check("R4 irq off again", irq, 0);
    check("R4 chg_en untouched", chg_en, 32'h000100);
    write_cfg(2'd2, 24'h000001);
    clear_flag();
    check("R4 irq follows clear", irq, 0);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; pins = '0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = '0;
    flag_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_edges_latency();
    t_sticky();
    t_set_wins();
    t_disabled();
    t_enable_no_false();
    t_pullup();
    t_irq_gate();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule